// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column read or write command into the stream of column addresses that a burst touches. A mode word, written while the block is idle, picks the burst length (one, two, four, eight beats or a full page) and the ordering (sequential or interleaved). A start pulse with a column then opens a burst, and the block presents one column per beat on a valid/ready output stream. It flags the final beat of every finite burst. It stays inside the column block aligned to the burst length and wraps around within that block.

A fresh start pulse may arrive on any cycle. It throws away whatever remains of the running burst and begins a new burst of full length at the new column. A stop pulse ends the burst at once. Full-page bursts never end by themselves. They step sequentially through the whole page, wrap at the page edge, and run until a stop or a new start arrives.

Back-pressure rules: a beat is consumed only on a cycle where `col_valid` and `col_ready` are both high. While `col_valid` is high and `col_ready` is low, the column and the last flag hold their values. Start and stop pulses act whatever the state of `col_ready`.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset `col_valid` and `col_last` are 0, the burst length is one beat and the ordering is sequential.
- R2: On a cycle with `mode_we` high, `mode_word[2:0]` sets the length: 000=1, 001=2, 010=4, 011=8, 111=full page. The codes 100, 101 and 110 give one beat. `mode_word[3]` sets the ordering: 0=sequential, 1=interleaved.
- R3: `mode_we` is ignored while `col_valid` is 1, so the running burst and the next burst keep the old length.
- R4: The cycle after `go` is high, `col_valid` is 1 and `col_addr` equals the `go_col` that was sampled.
- R5: In sequential order, beat i of a burst of length BL has the upper bits of the start column (above log2 BL) and low bits (start+i) mod BL.
- R6: In interleaved order, beat i has the upper bits of the start column and low bits start XOR i.
- R7: `col_last` is 1 only on the final beat of a finite burst. Once that beat is accepted, `col_valid` is 0 on the next cycle unless `go` was high.
- R8: While `col_valid` is 1 and `col_ready` is 0, `col_addr` and `col_last` hold their values.
- R9: A full-page burst never raises `col_last`. It runs sequentially modulo 2^COL_W and disregards `mode_word[3]`.
- R10: A `go` pulse during a burst restarts the sequence from the new column with the full length.
- R11: `halt` makes `col_valid` 0 on the next cycle. When `go` and `halt` are high together, `go` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_word | input | 4 | [2:0] length code, [3] ordering |
| go | input | 1 | Start a burst at `go_col` |
| go_col | input | COL_W | Start column |
| halt | input | 1 | Burst-stop pulse |
| col_valid | output | 1 | Output beat present |
| col_ready | input | 1 | Consumer accepts the beat |
| col_addr | output | COL_W | Column of the current beat |
| col_last | output | 1 | Final beat of a finite burst |

## Verification
The hardest case to reach from the ports is a restart that lands on a beat the consumer accepts at the same edge. This has to be paired with a mode write that arrives mid-burst, and checked against the old length. The stimulus walks a burst part way and then raises `go` with `col_ready` high, so that the accept and the restart collide. Separately, it writes a different length while a burst is live and then times two whole bursts. The full-page wrap is reached by starting a few columns below the page edge.

// File: rtl/sdcol_pkg.sv
package sdcol_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  // Offset mask for a length code; page mode masks every column bit.
  function automatic logic [15:0] len_mask(input logic [2:0] code);
    case (code)
      LEN_2:    len_mask = 16'h0001;
      LEN_4:    len_mask = 16'h0003;
      LEN_8:    len_mask = 16'h0007;
      LEN_PAGE: len_mask = 16'hFFFF;
      default:  len_mask = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/sdcol_mode.sv
module sdcol_mode
  import sdcol_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             wr,
  input  logic [3:0]       word,
  output logic [COL_W-1:0] mask,
  output logic             page,
  output logic             xor_ord
);
  logic [15:0] mask_full;
  assign mask_full = len_mask(word[2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask    <= '0;
      page    <= 1'b0;
      xor_ord <= 1'b0;
    end else if (wr && !busy) begin
      mask    <= mask_full[COL_W-1:0];
      page    <= (word[2:0] == LEN_PAGE);
      xor_ord <= word[3];
    end
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mask) && $stable(page) && $stable(xor_ord))) else $error("mode changed in burst"); // R3
endmodule

// File: rtl/sdcol_beat.sv
module sdcol_beat #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [COL_W-1:0] go_col,
  input  logic             halt,
  input  logic             ready,
  input  logic [COL_W-1:0] mask,
  input  logic             page,
  output logic             active,
  output logic             final_beat,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] step
);
  logic accept;
  assign accept     = active && ready;
  assign final_beat = active && !page && (step == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      step   <= '0;
    end else if (go) begin
      active <= 1'b1;
      base   <= go_col;
      step   <= '0;
    end else if (halt) begin
      active <= 1'b0;
    end else if (accept) begin
      if (final_beat) active <= 1'b0;
      else            step   <= step + 1'b1;
    end
  end

  AST_GO_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (active && step == '0 && base == $past(go_col))) else $error("restart"); // R10
  AST_HALT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !go) |=> !active) else $error("halt"); // R11
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (final_beat && ready && !go) |=> !active) else $error("last"); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ready && !go && !halt) |=> (active && $stable(step) && $stable(base))) else $error("stall"); // R8
endmodule

// File: rtl/sdcol_order.sv
module sdcol_order #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] step,
  input  logic [COL_W-1:0] mask,
  input  logic             xor_ord,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  assign sum = base + step;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!mask[b])     col[b] = base[b];
      else if (xor_ord) col[b] = base[b] ^ step[b];
      else              col[b] = sum[b];
    end
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [3:0]       mode_word,
  input  logic             go,
  input  logic [COL_W-1:0] go_col,
  input  logic             halt,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);
  logic [COL_W-1:0] mask, base, step;
  logic             page, xor_ord, active, final_beat;

  sdcol_mode #(.COL_W(COL_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .busy(active), .wr(mode_we), .word(mode_word),
    .mask(mask), .page(page), .xor_ord(xor_ord)
  );

  sdcol_beat #(.COL_W(COL_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .go(go), .go_col(go_col), .halt(halt),
    .ready(col_ready), .mask(mask), .page(page), .active(active),
    .final_beat(final_beat), .base(base), .step(step)
  );

  sdcol_order #(.COL_W(COL_W)) u_order (
    .base(base), .step(step), .mask(mask), .xor_ord(xor_ord && !page),
    .col(col_addr)
  );

  assign col_valid = active;
  assign col_last  = final_beat;

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid) else $error("last w/o valid"); // R7
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    page |-> !col_last) else $error("page last"); // R9
  AST_GO_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (col_valid && col_addr == $past(go_col))) else $error("first col"); // R4
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !go && !halt) |=> ($stable(col_addr) && $stable(col_last))) else $error("stall out"); // R8
endmodule

// File: tb/sdram_col_seq_bench.sv
`timescale 1ns/1ps
module sdram_col_seq_bench;
  localparam int COL_W = 9;
  logic clk = 0, rst_n = 0;
  logic mode_we = 0, go = 0, halt = 0, col_ready = 0;
  logic [3:0] mode_word = 0;
  logic [COL_W-1:0] go_col = 0;
  logic col_valid, col_last;
  logic [COL_W-1:0] col_addr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sdram_col_seq #(.COL_W(COL_W)) u_sdram_col_seq (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_word(mode_word),
    .go(go), .go_col(go_col), .halt(halt), .col_valid(col_valid),
    .col_ready(col_ready), .col_addr(col_addr), .col_last(col_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  function automatic int exp_col(int c, int blen, bit il, int i);
    int m = blen - 1;
    int off = il ? ((c ^ i) & m) : ((c + i) & m);
    return (c & ~m & 511) | off;
  endfunction

  task automatic beat(input string req, input int ec, input bit el);
    chk(col_valid == 1, req, col_valid, 1);
    chk(col_addr == ec, req, col_addr, ec);
    chk(col_last == el, {req, " last"}, col_last, el);
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_we = 1; mode_word = m; tick(); mode_we = 0;
  endtask

  task automatic launch(input int c);
    go = 1; go_col = c[COL_W-1:0]; tick(); go = 0;
  endtask

  // R2 R5 R6 R7 R8: one finite burst, optional stall before each beat
  task automatic run_burst(input int code, input bit il, input int c, input bit stall);
    int blen = (code <= 3) ? (1 << code) : 1;
    set_mode({il, code[2:0]});
    launch(c);
    for (int i = 0; i < blen; i++) begin
      if (stall) begin
        col_ready = 0;
        beat(il ? "R6 stall R8" : "R5 stall R8", exp_col(c, blen, il, i), i == blen - 1);
        tick();
      end
      col_ready = 1;
      beat(il ? "R6" : "R5", exp_col(c, blen, il, i), i == blen - 1);
      tick();
    end
    chk(col_valid == 0, "R7 end", col_valid, 0);
    col_ready = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(col_valid == 0, "R1 valid", col_valid, 0);
    chk(col_last == 0, "R1 last", col_last, 0);
    rst_n = 1; tick();
    // R1 default length 1 sequential
    launch(37);
    beat("R1 R4", 37, 1);
    col_ready = 1; tick(); col_ready = 0;
    chk(col_valid == 0, "R1 end", col_valid, 0);

    // sweep lengths, orders, start columns
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int c = 0; c < 32; c++)
          run_burst(code, il[0], c + ((c & 4) ? 256 : 0), c[0]);
    // illegal codes give one beat (R2)
    run_burst(4, 0, 5, 0);
    run_burst(5, 1, 6, 1);
    run_burst(6, 0, 7, 0);
    // stated example: interleaved 8 from 2 (R6)
    run_burst(3, 1, 2, 0);

    // R10 restart mid-burst with an accept on the same edge
    set_mode(4'b0011);
    launch(4);
    col_ready = 1;
    for (int i = 0; i < 3; i++) begin beat("R10 pre", 4 + i, 0); tick(); end
    go = 1; go_col = 9; tick(); go = 0;
    for (int i = 0; i < 8; i++) begin beat("R10", exp_col(9, 8, 0, i), i == 7); tick(); end
    chk(col_valid == 0, "R10 end", col_valid, 0);

    // R11 halt, and go beats halt
    launch(0);
    tick(); tick();
    halt = 1; tick(); halt = 0;
    chk(col_valid == 0, "R11 halt", col_valid, 0);
    chk(col_last == 0, "R11 last", col_last, 0);
    go = 1; halt = 1; go_col = 3; tick(); go = 0; halt = 0;
    col_ready = 0;
    beat("R11 go wins", 3, 0);
    halt = 1; tick(); halt = 0;
    chk(col_valid == 0, "R11 halt2", col_valid, 0);

    // R3 mode write ignored during burst
    set_mode(4'b0010);
    launch(0);
    col_ready = 1;
    mode_we = 1; mode_word = 4'b0011;
    beat("R3", 0, 0); tick(); mode_we = 0;
    for (int i = 1; i < 4; i++) begin beat("R3", i, i == 3); tick(); end
    chk(col_valid == 0, "R3 end", col_valid, 0);
    launch(0);
    for (int i = 0; i < 4; i++) begin beat("R3 next", i, i == 3); tick(); end
    chk(col_valid == 0, "R3 next end", col_valid, 0);

    // R9 full page, interleave bit set, wraps at 512
    set_mode(4'b1111);
    launch(508);
    for (int i = 0; i < 10; i++) begin beat("R9", (508 + i) % 512, 0); tick(); end
    chk(col_valid == 1, "R9 runs on", col_valid, 1);
    halt = 1; tick(); halt = 0;
    chk(col_valid == 0, "R9 halt", col_valid, 0);
    col_ready = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule